// File: doc/BRIEF.md
# Rejected Interrupt Resend Scanner

This block sits beside an interrupt source controller. When the interrupt presenter turns an interrupt away, the block notes the source. Later, on command, it replays every noted source to a downstream sender as a forced trigger, one at a time, in ascending source order. Each incoming rejected interrupt number is converted to a local source number by subtracting a configured base offset. Sources that fall outside the local window are dropped.

Storage is a two-level bitmap. A set of 64-bit words holds one bit per source. A summary vector holds one bit per word that has been touched since that word was last scanned. A resend pass only visits words whose summary bit is set. Each bit is cleared when its source is replayed, and each summary bit is cleared when scanning of its word begins. Every request is a forced send: the sender is expected to bypass its pending-state checks.

Top module: `rsnd_resend_scan`

## Requirements
- R1: The local source is `rej_irq - cfg_offset`. A reject is recorded only when `rej_irq >= cfg_offset` and the difference is below 2048 (32 words of 64 bits). Any other reject is ignored and never replayed.
- R2: A recorded reject of local source s sets bit s mod 64 of word s div 64 and summary bit s div 64 at the next clock edge. A source rejected several times before a resend is replayed once.
- R3: A resend pulse while the summary is all zero leaves `busy` low and raises no request.
- R4: A pass emits exactly one request per recorded source, in strictly ascending source number. Words are taken from index 0 to 31, and bits within a word from 0 to 63. `out_src` is word*64+bit.
- R5: Every replayed source is cleared, so a second resend with no new rejects in between emits nothing.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_src` stays unchanged.
- R7: `busy` rises on the edge that samples a resend with a non-empty summary. It stays high through acceptance of the final request of the pass, then falls. `out_valid` is never high while `busy` is low.
- R8: A resend pulse while `busy` is high is ignored: the current pass neither restarts nor repeats.
- R9: A reject arriving during a pass is recorded. It is replayed in the same pass if its source is above the source most recently latched for output. Otherwise it is replayed by the next resend.
- R10: `rst_n` low at a clock edge clears all words, the summary and the scan. `busy` and `out_valid` then read low, and a following resend emits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_offset | input | 16 | Interrupt number of local source 0 |
| rej_valid | input | 1 | A rejected interrupt is presented this cycle |
| rej_irq | input | 16 | Rejected interrupt number |
| resend | input | 1 | Start a replay pass (one-cycle pulse) |
| busy | output | 1 | A replay pass is in progress |
| out_valid | output | 1 | A forced-trigger request is offered |
| out_src | output | 11 | Local source number of the offered request |
| out_ready | input | 1 | Sender accepts the offered request |

## Verification
A reject can land in the same cycle as the scan it feeds. It can set a word or summary bit while the scanner is clearing that summary bit or latching a bit of that same word. The bench provokes this by holding `out_ready` low on the first replayed request. It then injects rejects below the current position, inside the current word above it, and in a later word, and adds a resend pulse while busy. It judges the outcome by the exact ordered list of sources this pass emits and the list the following pass emits.

// File: rtl/rsnd_pkg.sv
// Package: shared scan-state encoding for the rejected-interrupt resend scanner.
// Assumes: consumed only by the rsnd_* modules.
package rsnd_pkg;

    typedef enum logic [1:0] {
        SC_IDLE = 2'd0,   // no pass in progress
        SC_SEL  = 2'd1,   // choose next non-empty word at or above cursor
        SC_WORD = 2'd2,   // choose next set bit at or above bit cursor
        SC_EMIT = 2'd3    // request offered, waiting for acceptance
    } scan_state_e;

endpackage

// File: rtl/rsnd_first_set.sv
// Module: lowest-index set-bit finder.
// Does: reports whether any bit of vec is set and the index of the lowest one.
// Assumes: purely combinational; W is at least 2.
module rsnd_first_set #(
    parameter int W  = 64,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);

    // Walk from the top so the lowest set bit is assigned last.
    always_comb begin
        found = |vec;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end

endmodule

// File: rtl/rsnd_reject_map.sv
// Module: rejected-interrupt decoder.
// Does: subtracts the base offset and splits the local source into word and bit
//       indices; flags whether the source lies inside the local window.
// Assumes: IRQ_W >= WIDX_W + BIDX_W.
module rsnd_reject_map #(
    parameter int IRQ_W     = 16,
    parameter int NUM_WORDS = 32,
    parameter int WORD_BITS = 64,
    parameter int WIDX_W    = $clog2(NUM_WORDS),
    parameter int BIDX_W    = $clog2(WORD_BITS)
) (
    input  logic              rej_valid,
    input  logic [IRQ_W-1:0]  rej_irq,
    input  logic [IRQ_W-1:0]  cfg_offset,
    output logic              rec_valid,
    output logic [WIDX_W-1:0] rec_word,
    output logic [BIDX_W-1:0] rec_bit
);

    localparam int NSRC = NUM_WORDS * WORD_BITS;

    logic [IRQ_W:0] diff;
    logic           in_window;

    // Offset subtraction with a borrow bit to catch numbers below the base.
    always_comb begin
        diff      = {1'b0, rej_irq} - {1'b0, cfg_offset};
        in_window = !diff[IRQ_W] && (32'(diff[IRQ_W-1:0]) < 32'(NSRC));
        rec_valid = rej_valid && in_window;
        rec_word  = diff[BIDX_W +: WIDX_W];
        rec_bit   = diff[BIDX_W-1:0];
    end

endmodule

// File: rtl/rsnd_scanner.sv
// Module: replay scanner.
// Does: on a resend with a non-empty summary, walks summary bits upward from a
//       word cursor and set bits upward from a bit cursor, clearing each summary
//       bit as its word is entered and each source bit as it is latched, and
//       offers one request per source with a valid/ready handshake.
// Assumes: cur_word is the bitmap word selected by wcur, driven by the parent.
module rsnd_scanner
    import rsnd_pkg::*;
#(
    parameter int NUM_WORDS = 32,
    parameter int WORD_BITS = 64,
    parameter int WIDX_W    = $clog2(NUM_WORDS),
    parameter int BIDX_W    = $clog2(WORD_BITS),
    parameter int SRC_W     = WIDX_W + BIDX_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 resend,
    input  logic [NUM_WORDS-1:0] sum_vec,
    input  logic [WORD_BITS-1:0] cur_word,
    input  logic                 out_ready,
    output logic [WIDX_W-1:0]    wcur,
    output logic                 sum_clr,
    output logic [WIDX_W-1:0]    sum_clr_idx,
    output logic                 bit_clr,
    output logic [BIDX_W-1:0]    bit_clr_idx,
    output logic                 out_valid,
    output logic [SRC_W-1:0]     out_src,
    output logic                 busy
);

    localparam logic [WIDX_W-1:0] LAST_W = WIDX_W'(NUM_WORDS - 1);
    localparam logic [BIDX_W-1:0] LAST_B = BIDX_W'(WORD_BITS - 1);

    scan_state_e          state_q;
    logic [WIDX_W-1:0]    wcur_q;
    logic [BIDX_W-1:0]    bcur_q;
    logic                 ov_q;
    logic [SRC_W-1:0]     osrc_q;
    logic [NUM_WORDS-1:0] sum_masked;
    logic [WORD_BITS-1:0] word_masked;
    logic                 s_found, b_found;
    logic [WIDX_W-1:0]    s_idx;
    logic [BIDX_W-1:0]    b_idx;

    // Hide entries below the cursors so a pass only moves upward.
    always_comb begin
        sum_masked  = sum_vec  & ({NUM_WORDS{1'b1}} << wcur_q);
        word_masked = cur_word & ({WORD_BITS{1'b1}} << bcur_q);
    end

    rsnd_first_set #(.W(NUM_WORDS), .IW(WIDX_W)) u_sum_find (
        .vec(sum_masked), .found(s_found), .idx(s_idx)
    );

    rsnd_first_set #(.W(WORD_BITS), .IW(BIDX_W)) u_bit_find (
        .vec(word_masked), .found(b_found), .idx(b_idx)
    );

    // Clear strobes toward the bitmap.
    always_comb begin
        sum_clr     = (state_q == SC_SEL) && s_found;
        sum_clr_idx = s_idx;
        bit_clr     = (state_q == SC_WORD) && b_found;
        bit_clr_idx = b_idx;
    end

    // Scan state machine and output request register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SC_IDLE;
            wcur_q  <= '0;
            bcur_q  <= '0;
            ov_q    <= 1'b0;
            osrc_q  <= '0;
        end else begin
            case (state_q)
                SC_IDLE: begin
                    if (resend && |sum_vec) begin
                        state_q <= SC_SEL;
                        wcur_q  <= '0;
                    end
                end
                SC_SEL: begin
                    if (s_found) begin
                        state_q <= SC_WORD;
                        wcur_q  <= s_idx;
                        bcur_q  <= '0;
                    end else begin
                        state_q <= SC_IDLE;
                    end
                end
                SC_WORD: begin
                    if (b_found) begin
                        state_q <= SC_EMIT;
                        ov_q    <= 1'b1;
                        osrc_q  <= {wcur_q, b_idx};
                        bcur_q  <= b_idx;
                    end else if (wcur_q == LAST_W) begin
                        state_q <= SC_IDLE;
                    end else begin
                        wcur_q  <= wcur_q + WIDX_W'(1);
                        state_q <= SC_SEL;
                    end
                end
                SC_EMIT: begin
                    if (out_ready) begin
                        ov_q <= 1'b0;
                        if (bcur_q != LAST_B) begin
                            bcur_q  <= bcur_q + BIDX_W'(1);
                            state_q <= SC_WORD;
                        end else if (wcur_q == LAST_W) begin
                            state_q <= SC_IDLE;
                        end else begin
                            wcur_q  <= wcur_q + WIDX_W'(1);
                            state_q <= SC_SEL;
                        end
                    end
                end
                default: state_q <= SC_IDLE;
            endcase
        end
    end

    assign wcur      = wcur_q;
    assign out_valid = ov_q;
    assign out_src   = osrc_q;
    assign busy      = (state_q != SC_IDLE);

    // Ordering monitor: last accepted source within the current pass.
    logic             seen_q;
    logic [SRC_W-1:0] last_q;
    always_ff @(posedge clk) begin
        if (!rst_n || state_q == SC_IDLE) begin
            seen_q <= 1'b0;
            last_q <= '0;
        end else if (ov_q && out_ready) begin
            seen_q <= 1'b1;
            last_q <= osrc_q;
        end
    end

    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_src))); // R6
    AST_VALID_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> busy); // R7
    AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && seen_q) |-> (out_src > last_q)); // R4
    AST_BUSY_IGNORES_RESEND: assert property (@(posedge clk) disable iff (!rst_n)
        (resend && state_q == SC_EMIT && !out_ready) |=> (state_q == SC_EMIT)); // R8

endmodule

// File: rtl/rsnd_resend_scan.sv
// Module: rejected-interrupt resend scanner (top).
// Does: holds the two-level reject bitmap (per-source words plus a per-word
//       summary), records rejects through the decoder and replays them through
//       the scanner as forced-trigger requests.
// Assumes: resend is a one-cycle pulse; a reject setting a bit wins over a clear
//          of the same bit in the same cycle, so no reject is ever lost.
module rsnd_resend_scan #(
    parameter int IRQ_W     = 16,
    parameter int NUM_WORDS = 32,
    parameter int WORD_BITS = 64,
    localparam int WIDX_W   = $clog2(NUM_WORDS),
    localparam int BIDX_W   = $clog2(WORD_BITS),
    localparam int SRC_W    = WIDX_W + BIDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IRQ_W-1:0] cfg_offset,
    input  logic             rej_valid,
    input  logic [IRQ_W-1:0] rej_irq,
    input  logic             resend,
    output logic             busy,
    output logic             out_valid,
    output logic [SRC_W-1:0] out_src,
    input  logic             out_ready
);

    logic                 rec_valid;
    logic [WIDX_W-1:0]    rec_word;
    logic [BIDX_W-1:0]    rec_bit;
    logic [WIDX_W-1:0]    wcur;
    logic                 sum_clr, bit_clr;
    logic [WIDX_W-1:0]    sum_clr_idx;
    logic [BIDX_W-1:0]    bit_clr_idx;
    logic [WORD_BITS-1:0] words_q  [NUM_WORDS];
    logic [WORD_BITS-1:0] word_nxt [NUM_WORDS];
    logic                 sum_nxt  [NUM_WORDS];
    logic [NUM_WORDS-1:0] sum_q;
    logic [WORD_BITS-1:0] cur_word;

    rsnd_reject_map #(
        .IRQ_W(IRQ_W), .NUM_WORDS(NUM_WORDS), .WORD_BITS(WORD_BITS),
        .WIDX_W(WIDX_W), .BIDX_W(BIDX_W)
    ) u_map (
        .rej_valid(rej_valid), .rej_irq(rej_irq), .cfg_offset(cfg_offset),
        .rec_valid(rec_valid), .rec_word(rec_word), .rec_bit(rec_bit)
    );

    // Per-word next value: scanner clear first, then reject set on top.
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic hit_set, hit_clr, hit_sclr;
        assign hit_set  = rec_valid && (rec_word == WIDX_W'(w));
        assign hit_clr  = bit_clr && (wcur == WIDX_W'(w));
        assign hit_sclr = sum_clr && (sum_clr_idx == WIDX_W'(w));
        assign word_nxt[w] =
            (words_q[w] & ~(hit_clr ? (WORD_BITS'(1) << bit_clr_idx) : '0)) |
            (hit_set ? (WORD_BITS'(1) << rec_bit) : '0);
        assign sum_nxt[w] = (sum_q[w] && !hit_sclr) || hit_set;
    end

    // Bitmap and summary registers.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_WORDS; i++) begin
            if (!rst_n) begin
                words_q[i] <= '0;
                sum_q[i]   <= 1'b0;
            end else begin
                words_q[i] <= word_nxt[i];
                sum_q[i]   <= sum_nxt[i];
            end
        end
    end

    assign cur_word = words_q[wcur];

    rsnd_scanner #(
        .NUM_WORDS(NUM_WORDS), .WORD_BITS(WORD_BITS),
        .WIDX_W(WIDX_W), .BIDX_W(BIDX_W), .SRC_W(SRC_W)
    ) u_scan (
        .clk(clk), .rst_n(rst_n), .resend(resend), .sum_vec(sum_q),
        .cur_word(cur_word), .out_ready(out_ready), .wcur(wcur),
        .sum_clr(sum_clr), .sum_clr_idx(sum_clr_idx),
        .bit_clr(bit_clr), .bit_clr_idx(bit_clr_idx),
        .out_valid(out_valid), .out_src(out_src), .busy(busy)
    );

    AST_REJ_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |=> words_q[$past(rec_word)][$past(rec_bit)]); // R2
    AST_REJ_SETS_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |=> sum_q[$past(rec_word)]); // R2
    AST_EMPTY_RESEND: assert property (@(posedge clk) disable iff (!rst_n)
        (resend && !busy && sum_q == '0) |=> !busy); // R3
    AST_PASS_START: assert property (@(posedge clk) disable iff (!rst_n)
        (resend && !busy && sum_q != '0) |=> busy); // R7

endmodule

// File: tb/rsnd_resend_scan_test.sv
// Bench: table-driven reject/replay check followed by directed corner cases.
module rsnd_resend_scan_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_offset = 16'd100;
    logic        rej_valid = 1'b0;
    logic [15:0] rej_irq = '0;
    logic        resend = 1'b0;
    logic        busy, out_valid, out_ready = 1'b0;
    logic [10:0] out_src;

    int n_checks = 0;
    int n_fail   = 0;
    int got [64];
    int n_got;
    int exp_l [64];
    int n_exp;
    bit exp_bits [2048];

    always #2.5 clk = ~clk;

    rsnd_resend_scan uut (
        .clk(clk), .rst_n(rst_n), .cfg_offset(cfg_offset),
        .rej_valid(rej_valid), .rej_irq(rej_irq), .resend(resend),
        .busy(busy), .out_valid(out_valid), .out_src(out_src),
        .out_ready(out_ready)
    );

    // Rows: rejected interrupt number, expected local source (-1 = ignored).
    localparam int VEC [12][2] = '{
        '{100, 0}, '{99, -1}, '{163, 63}, '{164, 64}, '{2147, 2047},
        '{2148, -1}, '{600, 500}, '{163, 63}, '{1124, 1024}, '{0, -1},
        '{1430, 1330}, '{227, 127}
    };

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic do_reject(input int irq);
        @(negedge clk);
        rej_valid = 1'b1;
        rej_irq   = 16'(irq);
        @(negedge clk);
        rej_valid = 1'b0;
    endtask

    task automatic pulse_resend();
        @(negedge clk);
        resend = 1'b1;
        @(negedge clk);
        resend = 1'b0;
    endtask

    // Collect accepted requests until busy has been low for three samples.
    task automatic run_pass(input int mode);
        int idle = 0;
        int cyc = 0;
        int bad_hold = 0;
        int bad_busy = 0;
        logic prev_hold = 1'b0;
        logic [10:0] prev_src = '0;
        n_got = 0;
        while (idle < 3 && cyc < 6000) begin
            @(negedge clk);
            cyc++;
            if (prev_hold && !(out_valid && out_src == prev_src)) bad_hold++;
            if (out_valid && !busy) bad_busy++;
            out_ready = (mode == 0) ? 1'b1 : (cyc % 3 != 0);
            if (out_valid && out_ready && n_got < 64) begin
                got[n_got] = int'(out_src);
                n_got++;
            end
            prev_hold = out_valid && !out_ready;
            prev_src  = out_src;
            idle = busy ? 0 : idle + 1;
        end
        out_ready = 1'b0;
        check(bad_hold == 0, "R6 hold under backpressure", bad_hold, 0);
        check(bad_busy == 0, "R7 valid only while busy", bad_busy, 0);
    endtask

    task automatic compare(input string req);
        check(n_got == n_exp, req, n_got, n_exp);
        for (int i = 0; i < n_exp && i < n_got; i++)
            check(got[i] == exp_l[i], req, got[i], exp_l[i]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(!busy, "R10 busy after reset", int'(busy), 0);
        check(!out_valid, "R10 valid after reset", int'(out_valid), 0);

        // R3 resend with empty summary
        pulse_resend();
        run_pass(0);
        n_exp = 0;
        compare("R3 empty resend");

        // Table: R1 window, R2 recording and duplicates, R4 order
        for (int i = 0; i < 2048; i++) exp_bits[i] = 1'b0;
        for (int r = 0; r < 12; r++) begin
            do_reject(VEC[r][0]);
            if (VEC[r][1] >= 0) exp_bits[VEC[r][1]] = 1'b1;
        end
        n_exp = 0;
        for (int i = 0; i < 2048; i++)
            if (exp_bits[i]) begin exp_l[n_exp] = i; n_exp++; end
        pulse_resend();
        run_pass(1);
        compare("R1 R2 R4 table replay");

        // R5: everything was cleared
        pulse_resend();
        run_pass(0);
        n_exp = 0;
        compare("R5 second resend empty");

        // R9 and R8: rejects and a resend during a stalled pass
        do_reject(430);
        do_reject(740);
        pulse_resend();
        for (int k = 0; k < 20 && !out_valid; k++) @(negedge clk);
        check(out_valid && out_src == 11'd330, "R4 first request", int'(out_src), 330);
        do_reject(165);
        do_reject(440);
        do_reject(1380);
        do_reject(420);
        pulse_resend();
        check(out_valid && out_src == 11'd330, "R6 held while stalled", int'(out_src), 330);
        run_pass(0);
        n_exp = 4;
        exp_l[0] = 330; exp_l[1] = 340; exp_l[2] = 640; exp_l[3] = 1280;
        compare("R9 R8 same-pass pickup");
        pulse_resend();
        run_pass(0);
        n_exp = 2;
        exp_l[0] = 65; exp_l[1] = 320;
        compare("R9 deferred to next pass");

        // R10: reset in the middle of a pass
        do_reject(105);
        do_reject(106);
        pulse_resend();
        for (int k = 0; k < 20 && !out_valid; k++) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check(!busy, "R10 busy after mid-pass reset", int'(busy), 0);
        check(!out_valid, "R10 valid after mid-pass reset", int'(out_valid), 0);
        pulse_resend();
        run_pass(0);
        n_exp = 0;
        compare("R10 bitmap cleared");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule